// File: doc/BRIEF.md
# Channel Status Byte and Readout Sequencer

This block keeps the outcome of the most recent conversion for each input channel and turns it into two readable items: an 8-bit status byte and a formatted result word. The status byte holds the channel number, the reference-missing, sign and out-of-range flags from that conversion, and two live bits. A per-channel option bit decides what those two bits report. With the option clear they show a zero and the channel's ready flag. With the option set they show the levels of two general-purpose pins. The result word is the raw 24-bit conversion value. When clamping is on and the input was out of range, the word is forced to all ones or all zeros. In narrow mode only the upper 16 bits are kept.

A read is started with a one-cycle start strobe and an address bit that selects the status byte or the data. The block captures the bytes to send at that moment. It then presents them one at a time, and a byte-advance strobe steps to the next byte. In the chained ordering the status byte is followed directly by the data bytes. That ordering is used when the dump bit is set or when continuous-read mode is active. A done flag reports that the last byte was taken. Shifting the bytes out serially belongs to a neighbouring block.

Top module: `chan_status_readout`

## Requirements
- R1: After reset, every channel's status byte equals its channel number shifted into bits 7..5 with all other bits zero (channel 1 reads 20h). rd_valid and rd_done are low.
- R2: Status bits 7..5 carry the selected channel number. Bit 2 is the reference-missing flag, bit 1 is the sign flag (1 = negative) and bit 0 is over OR under. All three flags come from the last conversion captured for that channel on conv_valid.
- R3: When the channel's stat_opt bit is 0, status bit 4 is 0 and status bit 3 equals that channel's bit of rdy_flags.
- R4: When the channel's stat_opt bit is 1, status bit 4 equals pin0_lvl and status bit 3 equals pin1_lvl.
- R5: When clamp_en is 1, a stored over-range result forces the data word to all ones, and a stored under-range result forces it to all zeros, in the selected width.
- R6: When clamp_en is 0, the raw result passes to the data word unchanged, even when it is out of range.
- R7: When wide_en is 1, data_word is the 24-bit result and a data read sends 3 bytes. When wide_en is 0, data_word is {8'h00, result[23:8]} and a data read sends 2 bytes. In both widths bytes go most significant first.
- R8: When neither dump_en nor cont_rd_en is set, a read with rd_is_data=0 sends only the status byte, and a read with rd_is_data=1 sends only the data bytes.
- R9: When dump_en is 1, a read at either address sends the status byte followed immediately by the data bytes.
- R10: When cont_rd_en is 1, the chained status-then-data ordering is used even with dump_en at 0.
- R11: A rd_start while no read is in progress makes rd_valid high on the next cycle, showing the first byte. Each byte_adv while rd_valid is high shows the next byte on the next cycle. The byte stays stable while no advance arrives. Advancing past the last byte drops rd_valid and raises rd_done, which holds until the next rd_start. A rd_start during a read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | Capture a finished conversion for conv_ch |
| conv_ch | input | IDX_W | Channel the conversion belongs to |
| conv_raw | input | 24 | Raw conversion result |
| conv_over | input | 1 | Input was above the nominal range |
| conv_under | input | 1 | Input was below the nominal range |
| conv_neg | input | 1 | Input polarity was negative |
| conv_nref | input | 1 | Reference was missing during conversion |
| rdy_flags | input | NUM_CH | Per-channel ready flags |
| pin0_lvl | input | 1 | Level of general-purpose pin 0 |
| pin1_lvl | input | 1 | Level of general-purpose pin 1 |
| stat_opt | input | NUM_CH | Per-channel status option (pins instead of ready) |
| clamp_en | input | 1 | Clamp out-of-range results |
| wide_en | input | 1 | 1 = 24-bit data, 0 = 16-bit data |
| dump_en | input | 1 | Chain status byte ahead of data |
| cont_rd_en | input | 1 | Continuous-read mode, always chained |
| rd_ch | input | IDX_W | Channel selected for status, data and reads |
| rd_start | input | 1 | Start a read sequence |
| rd_is_data | input | 1 | Read address: 0 = status, 1 = data |
| byte_adv | input | 1 | Consume the current byte |
| status_byte | output | 8 | Live status byte for rd_ch |
| data_word | output | 24 | Formatted result for rd_ch |
| rd_byte | output | 8 | Current byte of the read sequence |
| rd_valid | output | 1 | rd_byte holds a byte to be taken |
| rd_done | output | 1 | Last byte of the sequence was taken |

## Verification
The hardest case to reach is a status byte that mixes stored flags with live bits. The channel field, the stored reference and sign flags, and the option-dependent bits 4 and 3 all have to be visible at once. The bench sets up that mix by capturing conversions on both channels with distinct flag sets. It then toggles the ready flags, the pins and the per-channel option one at a time and checks the byte after each change. A second hard case is a start strobe during a read in progress, which must leave the sequence untouched. The bench pulses rd_start with the other address in the middle of a chained read. It then confirms that the remaining bytes and the final done flag match the original sequence.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
    parameter int unsigned DATA_W   = 24;
    parameter int unsigned NARROW_W = 16;
    parameter int unsigned STAT_W   = 8;
    parameter int unsigned CHF_W    = 3;
    parameter int unsigned BYTE_W   = 8;

    typedef struct packed {
        logic [DATA_W-1:0] raw;
        logic              over;
        logic              under;
        logic              neg;
        logic              nref;
    } conv_rec_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_DONE = 2'd2
    } seq_st_t;
endpackage

// File: rtl/stat_bank.sv
module stat_bank
    import chstat_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_valid,
    input  logic [IDX_W-1:0] conv_ch,
    input  conv_rec_t        conv_in,
    input  logic [IDX_W-1:0] rd_ch,
    output conv_rec_t        rec_out
);
    conv_rec_t rec_d [NUM_CH];
    conv_rec_t rec_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            rec_d[g] = rec_q[g];
            if (conv_valid && (conv_ch == IDX_W'(g))) begin
                rec_d[g] = conv_in;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rec_q[g] <= '0;
            end else begin
                rec_q[g] <= rec_d[g];
            end
        end
    end

    assign rec_out = rec_q[rd_ch];
endmodule

// File: rtl/stat_byte_build.sv
module stat_byte_build
    import chstat_pkg::*;
#(
    parameter int unsigned IDX_W = 1
) (
    input  logic [IDX_W-1:0]  ch,
    input  logic              opt,
    input  logic              rdy,
    input  logic              pin0,
    input  logic              pin1,
    input  conv_rec_t         rec,
    output logic [STAT_W-1:0] stat
);
    logic [CHF_W-1:0] ch_field;
    logic             b4;
    logic             b3;

    always_comb begin
        ch_field = CHF_W'(ch);
        if (opt) begin
            b4 = pin0;
            b3 = pin1;
        end else begin
            b4 = 1'b0;
            b3 = rdy;
        end
        stat = {ch_field, b4, b3, rec.nref, rec.neg, rec.over | rec.under};
    end
endmodule

// File: rtl/data_fmt.sv
module data_fmt
    import chstat_pkg::*;
(
    input  conv_rec_t         rec,
    input  logic              clamp_en,
    input  logic              wide_en,
    output logic [DATA_W-1:0] word
);
    localparam int unsigned PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] clamped;

    always_comb begin
        if (clamp_en && rec.over) begin
            clamped = '1;
        end else if (clamp_en && rec.under) begin
            clamped = '0;
        end else begin
            clamped = rec.raw;
        end
        if (wide_en) begin
            word = clamped;
        end else begin
            word = {{PAD_W{1'b0}}, clamped[DATA_W-1 -: NARROW_W]};
        end
    end
endmodule

// File: rtl/read_seq.sv
module read_seq
    import chstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              rd_is_data,
    input  logic              dump_en,
    input  logic              cont_rd_en,
    input  logic              wide_en,
    input  logic [STAT_W-1:0] status_byte,
    input  logic [DATA_W-1:0] data_word,
    input  logic              byte_adv,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_valid,
    output logic              rd_done
);
    localparam int unsigned BUF_W     = STAT_W + DATA_W;
    localparam int unsigned MAX_BYTES = BUF_W / BYTE_W;
    localparam int unsigned CNT_W     = $clog2(MAX_BYTES);
    localparam int unsigned PAD_W     = DATA_W - NARROW_W;
    localparam int unsigned WIDE_N    = DATA_W / BYTE_W;
    localparam int unsigned NARROW_N  = NARROW_W / BYTE_W;

    typedef struct packed {
        seq_st_t          st;
        logic [BUF_W-1:0] shreg;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] last;
    } seq_t;

    seq_t s_d, s_q;

    logic [DATA_W-1:0] d_align;
    logic [CNT_W-1:0]  n_data;
    logic              chain;

    always_comb begin
        s_d     = s_q;
        chain   = dump_en || cont_rd_en;
        d_align = wide_en ? data_word : (data_word << PAD_W);
        n_data  = wide_en ? CNT_W'(WIDE_N) : CNT_W'(NARROW_N);
        case (s_q.st)
            SQ_IDLE, SQ_DONE: begin
                if (rd_start) begin
                    s_d.st  = SQ_SEND;
                    s_d.idx = '0;
                    if (chain) begin
                        s_d.shreg = {status_byte, d_align};
                        s_d.last  = n_data;
                    end else if (rd_is_data) begin
                        s_d.shreg = {d_align, {STAT_W{1'b0}}};
                        s_d.last  = n_data - CNT_W'(1);
                    end else begin
                        s_d.shreg = {status_byte, {DATA_W{1'b0}}};
                        s_d.last  = '0;
                    end
                end
            end
            SQ_SEND: begin
                if (byte_adv) begin
                    if (s_q.idx == s_q.last) begin
                        s_d.st = SQ_DONE;
                    end else begin
                        s_d.shreg = s_q.shreg << BYTE_W;
                        s_d.idx   = s_q.idx + CNT_W'(1);
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, shreg: '0, idx: '0, last: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_byte  = s_q.shreg[BUF_W-1 -: BYTE_W];
    assign rd_valid = (s_q.st == SQ_SEND);
    assign rd_done  = (s_q.st == SQ_DONE);

    // R11
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_start) |=> rd_valid);

    // R11
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && byte_adv && (s_q.idx == s_q.last)) |=> (rd_done && !rd_valid));

    // R11
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !byte_adv) |=> (rd_valid && $stable(rd_byte)));

    // R11
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_done));
endmodule

// File: rtl/chan_status_readout.sv
module chan_status_readout
    import chstat_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [IDX_W-1:0]  conv_ch,
    input  logic [DATA_W-1:0] conv_raw,
    input  logic              conv_over,
    input  logic              conv_under,
    input  logic              conv_neg,
    input  logic              conv_nref,
    input  logic [NUM_CH-1:0] rdy_flags,
    input  logic              pin0_lvl,
    input  logic              pin1_lvl,
    input  logic [NUM_CH-1:0] stat_opt,
    input  logic              clamp_en,
    input  logic              wide_en,
    input  logic              dump_en,
    input  logic              cont_rd_en,
    input  logic [IDX_W-1:0]  rd_ch,
    input  logic              rd_start,
    input  logic              rd_is_data,
    input  logic              byte_adv,
    output logic [STAT_W-1:0] status_byte,
    output logic [DATA_W-1:0] data_word,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_valid,
    output logic              rd_done
);
    conv_rec_t conv_in;
    conv_rec_t sel_rec;

    assign conv_in = '{raw: conv_raw, over: conv_over, under: conv_under,
                       neg: conv_neg, nref: conv_nref};

    stat_bank #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_valid (conv_valid),
        .conv_ch    (conv_ch),
        .conv_in    (conv_in),
        .rd_ch      (rd_ch),
        .rec_out    (sel_rec)
    );

    stat_byte_build #(.IDX_W(IDX_W)) u_stat (
        .ch   (rd_ch),
        .opt  (stat_opt[rd_ch]),
        .rdy  (rdy_flags[rd_ch]),
        .pin0 (pin0_lvl),
        .pin1 (pin1_lvl),
        .rec  (sel_rec),
        .stat (status_byte)
    );

    data_fmt u_fmt (
        .rec      (sel_rec),
        .clamp_en (clamp_en),
        .wide_en  (wide_en),
        .word     (data_word)
    );

    read_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_start    (rd_start),
        .rd_is_data  (rd_is_data),
        .dump_en     (dump_en),
        .cont_rd_en  (cont_rd_en),
        .wide_en     (wide_en),
        .status_byte (status_byte),
        .data_word   (data_word),
        .byte_adv    (byte_adv),
        .rd_byte     (rd_byte),
        .rd_valid    (rd_valid),
        .rd_done     (rd_done)
    );

    // R2
    chan_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[STAT_W-1 -: CHF_W] == CHF_W'(rd_ch));

    // R3
    opt_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_opt[rd_ch] |-> (status_byte[4] == 1'b0 && status_byte[3] == rdy_flags[rd_ch]));

    // R4
    opt_on_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_opt[rd_ch] |-> (status_byte[4] == pin0_lvl && status_byte[3] == pin1_lvl));

    // R5
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && sel_rec.over && wide_en) |-> (data_word == '1));

    // R7
    narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_en |-> (data_word[DATA_W-1 -: (DATA_W-NARROW_W)] == '0));
endmodule

// File: tb/chan_status_readout_tb.sv
module chan_status_readout_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [0:0]  conv_ch = '0;
    logic [23:0] conv_raw = '0;
    logic        conv_over = 1'b0, conv_under = 1'b0, conv_neg = 1'b0, conv_nref = 1'b0;
    logic [1:0]  rdy_flags = '0;
    logic        pin0_lvl = 1'b0, pin1_lvl = 1'b0;
    logic [1:0]  stat_opt = '0;
    logic        clamp_en = 1'b0, wide_en = 1'b1, dump_en = 1'b0, cont_rd_en = 1'b0;
    logic [0:0]  rd_ch = '0;
    logic        rd_start = 1'b0, rd_is_data = 1'b0, byte_adv = 1'b0;
    logic [7:0]  status_byte;
    logic [23:0] data_word;
    logic [7:0]  rd_byte;
    logic        rd_valid, rd_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    chan_status_readout #(.NUM_CH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
        .conv_raw(conv_raw), .conv_over(conv_over), .conv_under(conv_under),
        .conv_neg(conv_neg), .conv_nref(conv_nref), .rdy_flags(rdy_flags),
        .pin0_lvl(pin0_lvl), .pin1_lvl(pin1_lvl), .stat_opt(stat_opt),
        .clamp_en(clamp_en), .wide_en(wide_en), .dump_en(dump_en),
        .cont_rd_en(cont_rd_en), .rd_ch(rd_ch), .rd_start(rd_start),
        .rd_is_data(rd_is_data), .byte_adv(byte_adv), .status_byte(status_byte),
        .data_word(data_word), .rd_byte(rd_byte), .rd_valid(rd_valid), .rd_done(rd_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input int ch, input bit opt, input bit rdy,
        input bit p0, input bit p1, input bit nref, input bit neg, input bit ovr);
        logic [2:0] chf = 3'(ch);
        return opt ? {chf, p0, p1, nref, neg, ovr} : {chf, 1'b0, rdy, nref, neg, ovr};
    endfunction

    task automatic capture(input int ch, input logic [23:0] raw, input bit ov,
                           input bit un, input bit ng, input bit nr);
        @(negedge clk);
        conv_valid = 1'b1; conv_ch = 1'(ch); conv_raw = raw;
        conv_over = ov; conv_under = un; conv_neg = ng; conv_nref = nr;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    // exp holds bytes left-aligned, first byte in [31:24]
    task automatic do_read(input string req, input bit is_data, input int n,
                           input logic [31:0] exp);
        @(negedge clk);
        rd_start = 1'b1; rd_is_data = is_data;
        @(negedge clk);
        rd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(req, {31'b0, rd_valid}, 32'd1);
            check(req, {24'b0, rd_byte}, {24'b0, exp[31-8*i -: 8]});
            byte_adv = 1'b1;
            @(negedge clk);
            byte_adv = 1'b0;
        end
        check(req, {30'b0, rd_valid, rd_done}, 32'b01);
    endtask

    task automatic t_reset();
        rd_ch = 1'b0; #1;
        check("R1 ch0 status", {24'b0, status_byte}, 32'h00);
        rd_ch = 1'b1; #1;
        check("R1 ch1 status", {24'b0, status_byte}, 32'h20);
        check("R1 idle flags", {30'b0, rd_valid, rd_done}, 32'b00);
    endtask

    task automatic t_capture();
        capture(0, 24'h123456, 0, 0, 1, 0);
        capture(1, 24'hABCDEF, 1, 0, 0, 1);
        rd_ch = 1'b0; #1;
        check("R2 ch0 flags", {24'b0, status_byte}, {24'b0, exp_stat(0, 0, 0, 0, 0, 0, 1, 0)});
        rdy_flags = 2'b01; #1;
        check("R3 ch0 ready bit", {24'b0, status_byte}, {24'b0, exp_stat(0, 0, 1, 0, 0, 0, 1, 0)});
        rd_ch = 1'b1; #1;
        check("R2 ch1 flags", {24'b0, status_byte}, {24'b0, exp_stat(1, 0, 0, 0, 0, 1, 0, 1)});
        check("R6 raw passes over-range", {8'b0, data_word}, 32'hABCDEF);
        rdy_flags = 2'b00;
    endtask

    task automatic t_option();
        rd_ch = 1'b1; stat_opt = 2'b10; pin0_lvl = 1'b1; pin1_lvl = 1'b0; #1;
        check("R4 pin0 shown", {24'b0, status_byte}, {24'b0, exp_stat(1, 1, 0, 1, 0, 1, 0, 1)});
        pin1_lvl = 1'b1; rdy_flags = 2'b00; #1;
        check("R4 pin1 shown", {24'b0, status_byte}, {24'b0, exp_stat(1, 1, 0, 1, 1, 1, 0, 1)});
        stat_opt = 2'b00; rdy_flags = 2'b10; #1;
        check("R3 option off hides pins", {24'b0, status_byte}, {24'b0, exp_stat(1, 0, 1, 1, 1, 1, 0, 1)});
        rdy_flags = 2'b00; pin0_lvl = 1'b0; pin1_lvl = 1'b0;
    endtask

    task automatic t_clamp();
        rd_ch = 1'b1; clamp_en = 1'b1; wide_en = 1'b1; #1;
        check("R5 clamp over wide", {8'b0, data_word}, 32'hFFFFFF);
        wide_en = 1'b0; #1;
        check("R5 clamp over narrow", {8'b0, data_word}, 32'h00FFFF);
        capture(0, 24'h800001, 0, 1, 1, 0);
        rd_ch = 1'b0; wide_en = 1'b1; #1;
        check("R5 clamp under", {8'b0, data_word}, 32'h000000);
        clamp_en = 1'b0; #1;
        check("R6 under raw", {8'b0, data_word}, 32'h800001);
        wide_en = 1'b0; #1;
        check("R7 narrow upper bits", {8'b0, data_word}, 32'h008000);
        wide_en = 1'b1;
    endtask

    task automatic t_plain_reads();
        capture(0, 24'h123456, 0, 0, 1, 0);
        rd_ch = 1'b0; dump_en = 1'b0; cont_rd_en = 1'b0; wide_en = 1'b1;
        do_read("R8 status only", 1'b0, 1, 32'h02000000);
        do_read("R8 data wide", 1'b1, 3, 32'h12345600);
        wide_en = 1'b0;
        do_read("R7 data narrow", 1'b1, 2, 32'h12340000);
        wide_en = 1'b1;
    endtask

    task automatic t_dump_reads();
        dump_en = 1'b1;
        do_read("R9 dump via status", 1'b0, 4, 32'h02123456);
        do_read("R9 dump via data", 1'b1, 4, 32'h02123456);
        dump_en = 1'b0; cont_rd_en = 1'b1; wide_en = 1'b0;
        do_read("R10 continuous chained", 1'b1, 3, 32'h02123400);
        cont_rd_en = 1'b0; wide_en = 1'b1;
    endtask

    task automatic t_handshake();
        dump_en = 1'b1;
        @(negedge clk);
        rd_start = 1'b1; rd_is_data = 1'b0;
        @(negedge clk);
        rd_start = 1'b0;
        check("R11 first byte", {24'b0, rd_byte}, 32'h02);
        @(negedge clk);
        check("R11 hold without advance", {23'b0, rd_valid, rd_byte}, 32'h102);
        byte_adv = 1'b1;
        @(negedge clk);
        byte_adv = 1'b0;
        dump_en = 1'b0;
        rd_start = 1'b1; rd_is_data = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        check("R11 restart ignored", {23'b0, rd_valid, rd_byte}, 32'h112);
        for (int i = 0; i < 3; i++) begin
            byte_adv = 1'b1;
            @(negedge clk);
            byte_adv = 1'b0;
        end
        check("R11 done after last", {30'b0, rd_valid, rd_done}, 32'b01);
        repeat (2) @(negedge clk);
        check("R11 done holds", {30'b0, rd_valid, rd_done}, 32'b01);
        do_read("R11 new read clears done", 1'b0, 1, 32'h02000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_option();
        t_clamp();
        t_plain_reads();
        t_dump_reads();
        t_handshake();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule